// File: doc/BRIEF.md
# Zone Sample Sequencer

This block sets the timing of each sample taken by a low-power sensing front end. It runs from the fast system clock, and two strobes mark the slow real-time clock: one at its rising edge and one at its falling edge. A sample is a fixed series of measurement zones P, A, B, C and D. Each zone lasts the number of RTC cycles held in its own 3-bit length field. The sequencer can repeat the sample at a programmed period, filling the gap with a wait zone W. It can also take a single sample for each start, or run samples back to back with no gap.

Two bias channels follow the zones. Each channel has its own enable for each of zones P, A, B and C, and a polarity bit. Each channel can also narrow its pulse by half an RTC cycle at each end. A shared bias mode routes the bias pulses to the external pins, to the internal pins, to both or to neither. A wake pulse marks the start of a selected zone or the end of the sequence. One wake code also halts the sequencer after the sequence ends.

Top module: `zone_sample_sequencer`

## Requirements
- R1: `zone` reads 0 when idle, 1 in W, 2 in P, 3 in A, 4 in B, 5 in C and 6 in D. It changes only in the clock cycle after an `rtc_rise` strobe or after `run` is low. A sample visits P, A, B, C, D in that order, and each zone lasts its length in RTC cycles. The lengths are packed in `zone_len` as P[2:0], A[5:3], B[8:6], C[11:9], D[14:12].
- R2: A zone with length 0 is never entered. The sequencer goes on to the next zone that has a nonzero length.
- R3: For `period_code` 0 to 10, a new sample starts every 4·2^code RTC cycles. The block waits in W until that time has passed. If a sample runs longer than the period, the next sample starts on the same edge that ends D. Codes 11 to 13 use the longest period, 4096 cycles.
- R4: With `period_code` 14, each assertion of `run` yields one sample. After the sample the block stays idle until `run` goes low and then high again.
- R5: With `period_code` 15, the sequencer leaves the last zone and goes straight to the first nonzero zone among A to D. It passes through neither W nor P again.
- R6: `wake_sel` 1 to 5 selects the start of P, A, B, C or D. `wake` is high for exactly the one clock cycle after the `rtc_rise` on which that zone is entered.
- R7: `wake_sel` 6 pulses `wake` on the edge that ends the sequence. `wake_sel` 7 does the same and also sends the block idle until `run` is cleared. `wake_sel` 0 never pulses.
- R8: Within one clock cycle of `run` going low, `zone` is 0 and every bias output is at its inactive level. When `run` is high and the block is idle, the next `rtc_rise` starts a sample.
- R9: For channel k, `bias_zen[4k+3:4k]` enables zones P (bit 0), A (bit 1), B (bit 2) and C (bit 3). The pulse is high when `bias_pol[k]`=1 and low when it is 0. The inactive level is the inverse of the pulse level.
- R10: Bit 0 of `bias_mode` lets pulses reach `bias_ext` and bit 1 lets them reach `bias_int`. An output that is not routed stays at its inactive level.
- R11: With `bias_ofs[k]`=1, channel k asserts on the first `rtc_fall` inside its window and releases on the last `rtc_fall` before the window ends. A window of one RTC cycle never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_rise | input | 1 | One-cycle strobe at each RTC rising edge |
| rtc_fall | input | 1 | One-cycle strobe at each RTC falling edge |
| run | input | 1 | Sequencer start; low forces idle |
| period_code | input | 4 | Period / single / consecutive select |
| wake_sel | input | 3 | Wake event select |
| zone_len | input | 15 | Packed lengths of zones P..D |
| bias_zen | input | 8 | Per-channel zone enables |
| bias_pol | input | 2 | Per-channel pulse polarity |
| bias_ofs | input | 2 | Per-channel half-cycle narrowing |
| bias_mode | input | 2 | Route to external / internal pins |
| zone | output | 3 | Current zone code |
| wake | output | 1 | One-cycle wake pulse |
| bias_ext | output | 2 | External bias levels |
| bias_int | output | 2 | Internal bias levels |

## Verification
The bench builds the block with its default parameters: 3-bit zone lengths, two bias channels and a longest period code of 10. With 3-bit lengths, every zone length from 0 to 7 can be set. Period codes 0 to 2 are short enough to show three cases in tens of RTC cycles: a sample that waits in W, a sample that overruns its period, and back-to-back looping. The longest periods are left to the period arithmetic and are not run in full. Because there are two channels, one channel can use the half-cycle narrowing while the other runs plain in the same window, so the two can be compared cycle for cycle.

// File: rtl/zone_sample_sequencer.sv
module zone_sample_sequencer #(
  parameter int LEN_W      = 3,
  parameter int NZ         = 5,
  parameter int NB         = 2,
  parameter int PCODE_MAX  = 10,
  parameter int BASE_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rtc_rise,
  input  logic                  rtc_fall,
  input  logic                  run,
  input  logic [3:0]            period_code,
  input  logic [2:0]            wake_sel,
  input  logic [NZ*LEN_W-1:0]   zone_len,
  input  logic [NB*4-1:0]       bias_zen,
  input  logic [NB-1:0]         bias_pol,
  input  logic [NB-1:0]         bias_ofs,
  input  logic [1:0]            bias_mode,
  output logic [2:0]            zone,
  output logic                  wake,
  output logic [NB-1:0]         bias_ext,
  output logic [NB-1:0]         bias_int
);

  localparam int PER_W = BASE_SHIFT + PCODE_MAX + 1;
  localparam logic [2:0] Z_IDLE = 3'd0, Z_W = 3'd1, Z_P = 3'd2, Z_A = 3'd3;
  localparam logic [3:0] CODE_SINGLE = 4'd14, CODE_CONSEC = 4'd15;

  function automatic logic [2:0] seek(input logic [2:0] from_z, input logic [NZ*LEN_W-1:0] lens);
    logic [2:0] r;
    r = Z_IDLE;
    for (int i = NZ - 1; i >= 0; i--)
      if ((i + 2) >= int'(from_z) && lens[i*LEN_W +: LEN_W] != '0) r = 3'(i + 2);
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input logic [2:0] z, input logic [NZ*LEN_W-1:0] lens);
    logic [LEN_W-1:0] r;
    r = '0;
    for (int i = 0; i < NZ; i++)
      if (int'(z) == i + 2) r = lens[i*LEN_W +: LEN_W];
    return r;
  endfunction

  logic [2:0]       zone_q, n_zone;
  logic [LEN_W-1:0] cnt_q, n_cnt;
  logic [PER_W-1:0] pcnt_q, n_pcnt, per_lim, pc_inc;
  logic             spent_q, n_spent, wake_q, n_wake;
  logic [2:0]       start_z, nxt_z, loop_z;
  logic [3:0]       pc_eff;
  logic             enter, end_ev, period_hit;

  assign pc_eff     = (period_code > 4'(PCODE_MAX)) ? 4'(PCODE_MAX) : period_code;
  assign per_lim    = PER_W'(1) << (pc_eff + 4'(BASE_SHIFT));
  assign pc_inc     = (&pcnt_q) ? pcnt_q : pcnt_q + PER_W'(1);
  assign period_hit = pcnt_q >= per_lim;
  assign start_z    = seek(Z_P, zone_len);
  assign nxt_z      = seek(zone_q + 3'd1, zone_len);
  assign loop_z     = (seek(Z_A, zone_len) != Z_IDLE) ? seek(Z_A, zone_len) : start_z;

  always_comb begin
    n_zone  = zone_q;
    n_cnt   = cnt_q;
    n_pcnt  = pcnt_q;
    n_spent = spent_q;
    enter   = 1'b0;
    end_ev  = 1'b0;
    case (zone_q)
      Z_IDLE: if (!spent_q) begin
        n_zone = (start_z == Z_IDLE) ? Z_W : start_z;
        n_pcnt = PER_W'(1);
        enter  = 1'b1;
      end
      Z_W: if (period_hit) begin
        n_zone = (start_z == Z_IDLE) ? Z_W : start_z;
        n_pcnt = PER_W'(1);
        enter  = 1'b1;
      end else n_pcnt = pc_inc;
      default: begin
        n_pcnt = pc_inc;
        if (cnt_q > LEN_W'(1)) n_cnt = cnt_q - LEN_W'(1);
        else if (nxt_z != Z_IDLE) begin
          n_zone = nxt_z;
          enter  = 1'b1;
        end else begin
          end_ev = 1'b1;
          if (wake_sel == 3'd7 || period_code == CODE_SINGLE) begin
            n_zone  = Z_IDLE;
            n_spent = 1'b1;
          end else if (period_code == CODE_CONSEC) begin
            n_zone = loop_z;
            enter  = 1'b1;
          end else if (period_hit) begin
            n_zone = start_z;
            n_pcnt = PER_W'(1);
            enter  = 1'b1;
          end else n_zone = Z_W;
        end
      end
    endcase
    if (enter) n_cnt = len_of(n_zone, zone_len);
    n_wake = (enter && wake_sel != 3'd0 && wake_sel <= 3'd5 && n_zone == wake_sel + 3'd1) ||
             (end_ev && wake_sel >= 3'd6);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      zone_q  <= Z_IDLE;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      spent_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= rtc_rise & n_wake;
      if (rtc_rise) begin
        zone_q  <= n_zone;
        cnt_q   <= n_cnt;
        pcnt_q  <= n_pcnt;
        spent_q <= n_spent;
      end
    end
  end

  assign zone = zone_q;
  assign wake = wake_q;

  for (genvar k = 0; k < NB; k++) begin : g_bias
    logic [7:0] zmap;
    logic       raw_cur, raw_nxt, ofs_q, act;
    assign zmap    = {2'b00, bias_zen[k*4 +: 4], 2'b00};
    assign raw_cur = zmap[zone_q];
    assign raw_nxt = zmap[n_zone];
    always_ff @(posedge clk) begin
      if (!rst_n || !run) ofs_q <= 1'b0;
      else if (rtc_rise)  ofs_q <= ofs_q & raw_nxt;
      else if (rtc_fall)  ofs_q <= raw_cur & raw_nxt;
    end
    assign act         = bias_ofs[k] ? ofs_q : raw_cur;
    assign bias_ext[k] = ~bias_pol[k] ^ (bias_mode[0] & act);
    assign bias_int[k] = ~bias_pol[k] ^ (bias_mode[1] & act);
  end

endmodule

module zone_sample_sequencer_chk #(
  parameter int LEN_W = 3,
  parameter int NZ    = 5,
  parameter int NB    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rtc_rise,
  input logic                run,
  input logic [NZ*LEN_W-1:0] zone_len,
  input logic [NB-1:0]       bias_pol,
  input logic [1:0]          bias_mode,
  input logic [2:0]          zone,
  input logic                wake,
  input logic [NB-1:0]       bias_ext,
  input logic [NB-1:0]       bias_int
);
  AST_ZONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) zone <= 3'd6); // R1
  AST_ZONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$past(rtc_rise) && $past(run)) |-> $stable(zone)); // R1
  AST_SKIP_P: assert property (@(posedge clk) disable iff (!rst_n) (zone == 3'd2 && $past(zone) != 3'd2) |-> $past(zone_len[LEN_W-1:0]) != '0); // R2
  AST_SKIP_D: assert property (@(posedge clk) disable iff (!rst_n) (zone == 3'd6 && $past(zone) != 3'd6) |-> $past(zone_len[4*LEN_W +: LEN_W]) != '0); // R2
  AST_WAKE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n) wake |-> $past(rtc_rise)); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |=> zone == 3'd0); // R8
  AST_IDLE_BIAS: assert property (@(posedge clk) disable iff (!rst_n) zone == 3'd0 |-> (bias_ext == ~bias_pol && bias_int == ~bias_pol)); // R9
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n) bias_mode == 2'b00 |-> (bias_ext == ~bias_pol && bias_int == ~bias_pol)); // R10
endmodule

bind zone_sample_sequencer zone_sample_sequencer_chk #(.LEN_W(LEN_W), .NZ(NZ), .NB(NB)) chk_i (.*);

// File: tb/zone_sample_sequencer_tb_top.sv
module zone_sample_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_rise = 1'b0, rtc_fall = 1'b0, run = 1'b0;
  logic [3:0]  period_code = '0;
  logic [2:0]  wake_sel = '0;
  logic [14:0] zone_len = '0;
  logic [7:0]  bias_zen = '0;
  logic [1:0]  bias_pol = '0, bias_ofs = '0, bias_mode = '0;
  logic [2:0]  zone;
  logic        wake;
  logic [1:0]  bias_ext, bias_int;
  logic [1:0]  f_ext;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zone_sample_sequencer dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rtc_cycle();
    @(negedge clk) rtc_fall = 1'b1;
    @(negedge clk) rtc_fall = 1'b0;
    f_ext = bias_ext;
    @(negedge clk);
    @(negedge clk) rtc_rise = 1'b1;
    @(negedge clk) rtc_rise = 1'b0;
  endtask

  task automatic step(input string req, input int ez, input int ew);
    rtc_cycle();
    chk({req, " zone"}, int'(zone), ez);
    chk({req, " wake"}, int'(wake), ew);
  endtask

  task automatic set_lens(input int p, input int a, input int b, input int c, input int d);
    zone_len = {3'(d), 3'(c), 3'(b), 3'(a), 3'(p)};
  endtask

  task automatic halt();
    @(negedge clk) run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset zone", int'(zone), 0);
    chk("R8 reset wake", int'(wake), 0);
    chk("R9 reset ext inactive", int'(bias_ext), 3);
    chk("R9 reset int inactive", int'(bias_int), 3);
  endtask

  task automatic t_periodic();
    int ez[17];
    ez = '{2,3,3,4,5,5,5,6,1,1,1,1,1,1,1,1,2};
    set_lens(1,2,1,3,1); period_code = 4'd2; wake_sel = 3'd2;
    run = 1'b1;
    for (int k = 0; k < 17; k++) step("R1 R3 R6 periodic", ez[k], (k == 1) ? 1 : 0);
    @(negedge clk) chk("R6 wake one cycle", int'(wake), 0);
    halt();
  endtask

  task automatic t_skip();
    int ez[5];
    ez = '{3,5,5,1,3};
    set_lens(0,1,0,2,0); period_code = 4'd0; wake_sel = 3'd6;
    run = 1'b1;
    for (int k = 0; k < 5; k++) step("R2 R7 skip/end", ez[k], (k == 3) ? 1 : 0);
    halt();
  endtask

  task automatic t_overrun();
    int ez[7];
    ez = '{3,3,3,4,4,4,3};
    set_lens(0,3,3,0,0); period_code = 4'd0; wake_sel = 3'd0;
    run = 1'b1;
    for (int k = 0; k < 7; k++) step("R3 overrun", ez[k], 0);
    halt();
  endtask

  task automatic t_consec();
    int ez[9];
    ez = '{2,2,3,4,6,3,4,6,3};
    set_lens(2,1,1,0,1); period_code = 4'd15; wake_sel = 3'd1;
    run = 1'b1;
    for (int k = 0; k < 9; k++) step("R5 R6 consecutive", ez[k], (k == 0) ? 1 : 0);
    halt();
  endtask

  task automatic t_single();
    set_lens(1,1,0,0,0); period_code = 4'd14; wake_sel = 3'd0;
    run = 1'b1;
    step("R4 single", 2, 0);
    step("R4 single", 3, 0);
    step("R4 single", 0, 0);
    step("R4 single hold", 0, 0);
    halt();
    run = 1'b1;
    step("R4 single restart", 2, 0);
    halt();
  endtask

  task automatic t_stop();
    set_lens(1,1,0,0,0); period_code = 4'd0; wake_sel = 3'd7;
    run = 1'b1;
    step("R7 stop", 2, 0);
    step("R7 stop", 3, 0);
    step("R7 stop end", 0, 1);
    step("R7 stop hold", 0, 0);
    halt();
    run = 1'b1;
    step("R7 stop restart", 2, 0);
    halt();
  endtask

  task automatic t_runclear();
    set_lens(3,3,3,3,3); period_code = 4'd0; wake_sel = 3'd0;
    bias_zen = 8'b0000_0001; bias_pol = 2'b01; bias_mode = 2'b11; bias_ofs = 2'b00;
    run = 1'b1;
    step("R8 run", 2, 0);
    chk("R9 active before clear", int'(bias_ext), 2'b11);
    @(negedge clk) run = 1'b0;
    @(negedge clk);
    chk("R8 clear zone", int'(zone), 0);
    chk("R8 clear ext", int'(bias_ext), 2'b10);
    chk("R8 clear int", int'(bias_int), 2'b10);
  endtask

  task automatic t_bias();
    set_lens(1,1,1,1,1); period_code = 4'd15; wake_sel = 3'd0;
    bias_zen = 8'b0100_0011; bias_pol = 2'b01; bias_ofs = 2'b00; bias_mode = 2'b00;
    run = 1'b1;
    for (int k = 0; k < 20; k++) begin
      int z, md;
      logic [1:0] act, lvl;
      md = k / 5;
      bias_mode = 2'(md);
      z = (k == 0) ? 2 : 3 + ((k - 1) % 4);
      act = {(z == 4) ? 1'b1 : 1'b0, (z == 2 || z == 3) ? 1'b1 : 1'b0};
      step("R1 bias zone", z, 0);
      lvl = ~bias_pol ^ (act & {2{bias_mode[0]}});
      chk("R9 R10 ext level", int'(bias_ext), int'(lvl));
      lvl = ~bias_pol ^ (act & {2{bias_mode[1]}});
      chk("R9 R10 int level", int'(bias_int), int'(lvl));
    end
    halt();
  endtask

  task automatic t_offset();
    int ef[5], er[5];
    ef = '{0, 0, 3, 2, 0};
    er = '{0, 2, 3, 0, 0};
    set_lens(1,1,1,1,1); period_code = 4'd15; wake_sel = 3'd0;
    bias_zen = 8'b0110_0110; bias_pol = 2'b11; bias_ofs = 2'b01; bias_mode = 2'b01;
    run = 1'b1;
    for (int k = 0; k < 5; k++) begin
      rtc_cycle();
      chk("R11 after fall", int'(f_ext), ef[k]);
      chk("R11 after rise", int'(bias_ext), er[k]);
    end
    bias_zen = 8'b0000_0010;
    for (int k = 0; k < 4; k++) begin
      rtc_cycle();
      chk("R11 one-cycle window", int'(bias_ext[0]), 0);
      chk("R11 one-cycle window", int'(f_ext[0]), 0);
    end
    halt();
  endtask

  initial begin
    t_reset();
    t_periodic();
    t_skip();
    t_overrun();
    t_consec();
    t_single();
    t_stop();
    t_runclear();
    t_bias();
    t_offset();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule